// File: doc/BRIEF.md
# PHY Management Register Bridge

This block lets a host reach a small PHY register file that sits inside the chip. The host never addresses PHY registers directly. It goes through four byte-wide host registers:
- a PHY register-number register,
- the low byte of a 16-bit transfer register,
- the high byte of that transfer register,
- a command register.

A write to the command register starts the transfer at once, with no serial timing. A read copies the selected PHY register into the transfer register. A write copies the transfer register into the PHY register.

The PHY file holds three writable registers: control (number 0), advertisement (number 4) and specific configuration (number 16). Status register 1 is fixed, and six more registers return constants set by parameters. Setting bit 15 of the control register never stores that bit. It reloads the defaults of all three writable registers instead.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: Synchronous active-low reset clears the command, number and transfer registers to 0, and sets control to 0x3100, advertisement to 0x01E1 and configuration to 0x0410.
- R2: Host select encodes 0 = command, 1 = PHY number, 2 = transfer low byte, 3 = transfer high byte. The number register keeps and reads back all 8 bits written, but only bits 5:0 choose the PHY register.
- R3: A host write to one transfer byte leaves the other byte unchanged.
- R4: A command write with bit 2 or bit 3 set loads the selected PHY register into the transfer register on that clock edge. A command write with bit 1 set and bits 2 and 3 clear stores the transfer register into the selected PHY register. When both apply, the read wins and nothing is written.
- R5: A write to control register 0 with bit 15 clear stores the value unchanged.
- R6: A write to control register 0 with bit 15 set reloads control, advertisement and configuration with their R1 defaults.
- R7: A write to register 16 stores the value with bit 3 cleared. A write to register 4 stores the value unchanged.
- R8: PHY register 1 always reads 0x782D.
- R9: Registers 2, 3, 5, 6, 17 and 18 read as their parameter constants, and writes to them have no effect.
- R10: Unimplemented register numbers read as 0, and writes to them change no register.
- R11: The command register reads back the last value written to it.
- R12: A command write with bits 1, 2 and 3 all clear starts no transfer and leaves the transfer register and the PHY file unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 2 | Host register select (see R2) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected host register, combinational |

## Verification
Transfers are tried with:
- read-only command codes (0x04, 0x08, 0x0C),
- a write-only code (0x02),
- codes that set both read and write bits (0x0A, 0x0E),
- codes with no transfer bit (0x00, 0xF1).

Together these separate read priority from write priority and from no action. Each writable PHY register is written with patterns that set bit 15 and bit 3, so each write mask is exposed. Fixed and unimplemented numbers, including one that aliases register 0 in its low bits (0x20), show whether writes leak into the real registers.

// File: rtl/phy_bridge_pkg.sv
// Shared types and constants of the PHY management register bridge.
// Assumes a byte-wide host port and a 16-bit PHY register width.
package phy_bridge_pkg;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DLO  = 2'd2,
        SEL_DHI  = 2'd3
    } host_sel_e;

    localparam logic [7:0]  CMD_RD_MASK  = 8'h0C;
    localparam logic [7:0]  CMD_WR_MASK  = 8'h0A;

    localparam logic [5:0]  PHY_CTRL     = 6'd0;
    localparam logic [5:0]  PHY_STAT     = 6'd1;
    localparam logic [5:0]  PHY_ID_HI    = 6'd2;
    localparam logic [5:0]  PHY_ID_LO    = 6'd3;
    localparam logic [5:0]  PHY_ADV      = 6'd4;
    localparam logic [5:0]  PHY_PARTNER  = 6'd5;
    localparam logic [5:0]  PHY_EXPAND   = 6'd6;
    localparam logic [5:0]  PHY_CFG      = 6'd16;
    localparam logic [5:0]  PHY_SPSTAT   = 6'd17;
    localparam logic [5:0]  PHY_TENSTAT  = 6'd18;

    localparam logic [15:0] CTRL_DEFAULT = 16'h3100;
    localparam logic [15:0] ADV_DEFAULT  = 16'h01E1;
    localparam logic [15:0] CFG_DEFAULT  = 16'h0410;
    localparam logic [15:0] STAT_VALUE   = 16'h782D;
    localparam logic [15:0] CTRL_WMASK   = 16'h7FFF;
    localparam logic [15:0] CFG_WMASK    = 16'hFFF7;

endpackage

// File: rtl/phy_host_regs.sv
// Host-side registers: PHY number, byte-lane transfer register and command.
// Decodes a command write into a one-cycle read or write pulse, read first.
// Assumes DATA_W is a whole multiple of HOST_W and that there are two lanes.
module phy_host_regs
    import phy_bridge_pkg::*;
#(
    parameter int HOST_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  host_sel_e         host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic [HOST_W-1:0] addr_q,
    output logic [HOST_W-1:0] cmd_q,
    output logic [DATA_W-1:0] data_q,
    output logic              rd_go,
    output logic              wr_go
);
    localparam int LANES = DATA_W / HOST_W;

    logic cmd_wr;

    // Decode the command write; a read request beats a write request.
    always_comb begin
        cmd_wr = host_wr && (host_sel == SEL_CMD);
        rd_go  = cmd_wr && ((host_wdata & CMD_RD_MASK) != '0);
        wr_go  = cmd_wr && !rd_go && ((host_wdata & CMD_WR_MASK) != '0);
    end

    // Number and command registers, loaded by host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
        end else if (host_wr) begin
            if (host_sel == SEL_ADDR) addr_q <= host_wdata;
            if (host_sel == SEL_CMD)  cmd_q  <= host_wdata;
        end
    end

    // One byte lane of the transfer register per generate step.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        localparam host_sel_e LANE_SEL = host_sel_e'(SEL_DLO + ln);
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[ln*HOST_W +: HOST_W] <= '0;
            else if (rd_go)
                data_q[ln*HOST_W +: HOST_W] <= phy_rdata[ln*HOST_W +: HOST_W];
            else if (host_wr && (host_sel == LANE_SEL))
                data_q[ln*HOST_W +: HOST_W] <= host_wdata;
        end
    end

endmodule

// File: rtl/phy_reg_file.sv
// Internal PHY register file: three writable registers with write masks,
// a fixed status word and parameterised constant registers.
// Assumes writes arrive as single-cycle pulses. A control write with
// bit 15 set reloads the defaults instead of storing.
module phy_reg_file
    import phy_bridge_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          NUM_W     = 6,
    parameter logic [15:0] ID_HI     = 16'h0181,
    parameter logic [15:0] ID_LO     = 16'hB8C0,
    parameter logic [15:0] PARTNER   = 16'h45E1,
    parameter logic [15:0] EXPAND    = 16'h0001,
    parameter logic [15:0] SPSTAT    = 16'h8010,
    parameter logic [15:0] TENSTAT   = 16'h7800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NUM_W-1:0]  reg_num,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int TOP = DATA_W - 1;

    logic [DATA_W-1:0] ctrl_q, adv_q, cfg_q;
    logic              soft_rst;

    // Self-clearing reset request from a control write with the top bit set.
    always_comb soft_rst = wr_en && (reg_num == NUM_W'(PHY_CTRL)) && wr_data[TOP];

    // Writable registers: defaults on reset or soft reset, else masked write.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q <= CTRL_DEFAULT;
            adv_q  <= ADV_DEFAULT;
            cfg_q  <= CFG_DEFAULT;
        end else if (wr_en) begin
            case (reg_num)
                NUM_W'(PHY_CTRL): ctrl_q <= wr_data & CTRL_WMASK;
                NUM_W'(PHY_ADV):  adv_q  <= wr_data;
                NUM_W'(PHY_CFG):  cfg_q  <= wr_data & CFG_WMASK;
                default: ;
            endcase
        end
    end

    // Read mux over implemented numbers; everything else reads zero.
    always_comb begin
        case (reg_num)
            NUM_W'(PHY_CTRL):    rd_data = ctrl_q;
            NUM_W'(PHY_STAT):    rd_data = STAT_VALUE;
            NUM_W'(PHY_ID_HI):   rd_data = ID_HI;
            NUM_W'(PHY_ID_LO):   rd_data = ID_LO;
            NUM_W'(PHY_ADV):     rd_data = adv_q;
            NUM_W'(PHY_PARTNER): rd_data = PARTNER;
            NUM_W'(PHY_EXPAND):  rd_data = EXPAND;
            NUM_W'(PHY_CFG):     rd_data = cfg_q;
            NUM_W'(PHY_SPSTAT):  rd_data = SPSTAT;
            NUM_W'(PHY_TENSTAT): rd_data = TENSTAT;
            default:             rd_data = '0;
        endcase
    end

endmodule

// File: rtl/phy_mgmt_bridge.sv
// Top of the PHY management register bridge. Joins the host registers to the
// PHY file and muxes the selected host register onto host_rdata.
// Assumes one host access per cycle and a combinational read path.
module phy_mgmt_bridge
    import phy_bridge_pkg::*;
#(
    parameter int          HOST_W  = 8,
    parameter int          DATA_W  = 16,
    parameter int          NUM_W   = 6,
    parameter logic [15:0] ID_HI   = 16'h0181,
    parameter logic [15:0] ID_LO   = 16'hB8C0,
    parameter logic [15:0] PARTNER = 16'h45E1,
    parameter logic [15:0] EXPAND  = 16'h0001,
    parameter logic [15:0] SPSTAT  = 16'h8010,
    parameter logic [15:0] TENSTAT = 16'h7800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata
);
    host_sel_e         sel;
    logic [HOST_W-1:0] addr_q, cmd_q;
    logic [DATA_W-1:0] data_q, phy_rdata;
    logic              rd_go, wr_go;

    // Cast the raw select onto the shared enum.
    always_comb sel = host_sel_e'(host_sel);

    phy_host_regs #(.HOST_W(HOST_W), .DATA_W(DATA_W)) u_host (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(sel),
        .host_wdata(host_wdata), .phy_rdata(phy_rdata), .addr_q(addr_q),
        .cmd_q(cmd_q), .data_q(data_q), .rd_go(rd_go), .wr_go(wr_go)
    );

    phy_reg_file #(
        .DATA_W(DATA_W), .NUM_W(NUM_W), .ID_HI(ID_HI), .ID_LO(ID_LO),
        .PARTNER(PARTNER), .EXPAND(EXPAND), .SPSTAT(SPSTAT), .TENSTAT(TENSTAT)
    ) u_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .reg_num(addr_q[NUM_W-1:0]),
        .wr_data(data_q), .rd_data(phy_rdata)
    );

    // Host read-back mux.
    always_comb begin
        case (sel)
            SEL_CMD:  host_rdata = cmd_q;
            SEL_ADDR: host_rdata = addr_q;
            SEL_DLO:  host_rdata = data_q[HOST_W-1:0];
            default:  host_rdata = data_q[2*HOST_W-1:HOST_W];
        endcase
    end

endmodule

// File: rtl/phy_mgmt_bridge_chk.sv
// Assertion checker for the PHY management bridge, bound to the top module.
// Assumes the default widths: 8-bit host port, 16-bit PHY data, 6-bit number.
module phy_mgmt_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [1:0]  host_sel,
    input logic [7:0]  host_wdata,
    input logic [7:0]  addr_q,
    input logic [7:0]  cmd_q,
    input logic [15:0] data_q,
    input logic [15:0] phy_rdata
);
    logic       cmd_wr, rd_req, no_req, implemented;
    logic [5:0] num;

    // Independent decode of the host strobes and the implemented number set.
    always_comb begin
        num    = addr_q[5:0];
        cmd_wr = host_wr && (host_sel == 2'd0);
        rd_req = cmd_wr && (host_wdata[2] || host_wdata[3]);
        no_req = cmd_wr && !host_wdata[1] && !host_wdata[2] && !host_wdata[3];
        implemented = (num <= 6'd6) || (num >= 6'd16 && num <= 6'd18);
    end

    assert_cmd_echo_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> cmd_q == $past(host_wdata));

    assert_low_write_keeps_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd2) |=> data_q[15:8] == $past(data_q[15:8]));

    assert_high_write_keeps_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd3) |=> data_q[7:0] == $past(data_q[7:0]));

    assert_read_loads_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> data_q == $past(phy_rdata));

    assert_idle_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        no_req |=> $stable(data_q));

    assert_status_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (num == 6'd1) |-> phy_rdata == 16'h782D);

    assert_unimplemented_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !implemented |-> phy_rdata == 16'h0000);

    assert_ctrl_top_bit_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (num == 6'd0) |-> !phy_rdata[15]);

    assert_cfg_bit3_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (num == 6'd16) |-> !phy_rdata[3]);

endmodule

bind phy_mgmt_bridge phy_mgmt_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .addr_q(addr_q), .cmd_q(cmd_q),
    .data_q(data_q), .phy_rdata(phy_rdata)
);

// File: tb/test_phy_mgmt_bridge.sv
// Self-checking bench: a vector table of host write / read-back steps,
// then directed checks of fixed registers, unimplemented numbers and reset.
module test_phy_mgmt_bridge;
    localparam logic [1:0] S_CMD = 2'd0, S_ADR = 2'd1, S_DLO = 2'd2, S_DHI = 2'd3;
    localparam logic [15:0] K_ID_HI = 16'h1234, K_ID_LO = 16'h5678, K_PART = 16'h9ABC;
    localparam logic [15:0] K_EXP = 16'h0DEF, K_SPS = 16'hC3A5, K_TEN = 16'h6E01;
    localparam int NV = 64;
    // Step: {write select, write data, read select, expected byte, requirement}
    localparam logic [23:0] VEC [NV] = '{
        {S_ADR,8'h00,S_ADR,8'h00,4'd2},  {S_CMD,8'h0C,S_DLO,8'h00,4'd1},   // R2, R1
        {S_ADR,8'h00,S_DHI,8'h31,4'd1},  {S_ADR,8'h04,S_ADR,8'h04,4'd2},
        {S_CMD,8'h04,S_DLO,8'hE1,4'd1},  {S_ADR,8'h04,S_DHI,8'h01,4'd1},
        {S_ADR,8'h10,S_ADR,8'h10,4'd2},  {S_CMD,8'h08,S_DLO,8'h10,4'd1},
        {S_ADR,8'h10,S_DHI,8'h04,4'd1},  {S_ADR,8'h01,S_ADR,8'h01,4'd2},
        {S_CMD,8'h0C,S_DLO,8'h2D,4'd8},  {S_ADR,8'h01,S_DHI,8'h78,4'd8},   // R8
        {S_ADR,8'hC1,S_ADR,8'hC1,4'd2},  {S_DLO,8'h00,S_DLO,8'h00,4'd3},   // R2
        {S_CMD,8'h04,S_DHI,8'h78,4'd2},  {S_DLO,8'h55,S_DHI,8'h78,4'd3},   // R3
        {S_DHI,8'hAA,S_DLO,8'h55,4'd3},  {S_ADR,8'h00,S_ADR,8'h00,4'd5},   // R5
        {S_DLO,8'h34,S_DHI,8'hAA,4'd3},  {S_DHI,8'h12,S_DLO,8'h34,4'd3},
        {S_CMD,8'h02,S_CMD,8'h02,4'd11}, {S_DLO,8'h00,S_DLO,8'h00,4'd5},   // R11
        {S_DHI,8'h00,S_DHI,8'h00,4'd5},  {S_CMD,8'h04,S_DLO,8'h34,4'd5},
        {S_ADR,8'h00,S_DHI,8'h12,4'd5},  {S_ADR,8'h04,S_ADR,8'h04,4'd7},   // R7
        {S_DLO,8'h5A,S_DLO,8'h5A,4'd7},  {S_DHI,8'hA5,S_DHI,8'hA5,4'd7},
        {S_CMD,8'h02,S_DLO,8'h5A,4'd7},  {S_DLO,8'h00,S_DLO,8'h00,4'd7},
        {S_DHI,8'h00,S_DHI,8'h00,4'd7},  {S_CMD,8'h04,S_DLO,8'h5A,4'd7},
        {S_ADR,8'h04,S_DHI,8'hA5,4'd7},  {S_ADR,8'h10,S_ADR,8'h10,4'd7},
        {S_DLO,8'hFF,S_DLO,8'hFF,4'd7},  {S_DHI,8'hFF,S_DHI,8'hFF,4'd7},
        {S_CMD,8'h02,S_CMD,8'h02,4'd7},  {S_DLO,8'h00,S_DLO,8'h00,4'd7},
        {S_CMD,8'h04,S_DLO,8'hF7,4'd7},  {S_ADR,8'h10,S_DHI,8'hFF,4'd7},
        {S_ADR,8'h00,S_ADR,8'h00,4'd6},  {S_DLO,8'h00,S_DLO,8'h00,4'd6},   // R6
        {S_DHI,8'h80,S_DHI,8'h80,4'd6},  {S_CMD,8'h02,S_CMD,8'h02,4'd6},
        {S_DHI,8'h00,S_DHI,8'h00,4'd6},  {S_CMD,8'h04,S_DHI,8'h31,4'd6},
        {S_ADR,8'h00,S_DLO,8'h00,4'd6},  {S_ADR,8'h04,S_ADR,8'h04,4'd6},
        {S_CMD,8'h04,S_DLO,8'hE1,4'd6},  {S_ADR,8'h10,S_ADR,8'h10,4'd6},
        {S_CMD,8'h04,S_DLO,8'h10,4'd6},  {S_ADR,8'h04,S_ADR,8'h04,4'd4},   // R4
        {S_CMD,8'h0E,S_DLO,8'hE1,4'd4},  {S_DLO,8'h77,S_DLO,8'h77,4'd4},
        {S_CMD,8'h0A,S_DLO,8'hE1,4'd4},  {S_DLO,8'h33,S_DLO,8'h33,4'd4},
        {S_CMD,8'h02,S_DLO,8'h33,4'd4},  {S_DLO,8'h00,S_DLO,8'h00,4'd4},
        {S_CMD,8'h04,S_DLO,8'h33,4'd4},  {S_DLO,8'h66,S_DLO,8'h66,4'd12},  // R12
        {S_CMD,8'hF1,S_DLO,8'h66,4'd12}, {S_CMD,8'hF1,S_CMD,8'hF1,4'd11},
        {S_CMD,8'h00,S_DLO,8'h66,4'd12}, {S_CMD,8'h04,S_DLO,8'h33,4'd12}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    phy_mgmt_bridge #(
        .ID_HI(K_ID_HI), .ID_LO(K_ID_LO), .PARTNER(K_PART),
        .EXPAND(K_EXP), .SPSTAT(K_SPS), .TENSTAT(K_TEN)
    ) i_phy_mgmt_bridge (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic hwrite(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = s; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic check(input logic [1:0] s, input logic [7:0] exp, input string req);
        host_sel = s;
        #1;
        total++;
        if (host_rdata !== exp) begin
            bad++;
            $display("FAIL %s sel=%0d actual=%02h expected=%02h", req, s, host_rdata, exp);
        end
    endtask

    // Read one full PHY register through the transfer register.
    task automatic phy_read_check(input logic [5:0] n, input logic [15:0] exp, input string req);
        hwrite(S_ADR, {2'b00, n});
        hwrite(S_CMD, 8'h04);
        check(S_DLO, exp[7:0], req);
        check(S_DHI, exp[15:8], req);
    endtask

    task automatic phy_write(input logic [5:0] n, input logic [15:0] v);
        hwrite(S_ADR, {2'b00, n});
        hwrite(S_DLO, v[7:0]);
        hwrite(S_DHI, v[15:8]);
        hwrite(S_CMD, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: host registers after reset
        check(S_CMD, 8'h00, "R1");
        check(S_ADR, 8'h00, "R1");
        check(S_DLO, 8'h00, "R1");
        check(S_DHI, 8'h00, "R1");
        for (int i = 0; i < NV; i++) begin
            hwrite(VEC[i][23:22], VEC[i][21:14]);
            check(VEC[i][13:12], VEC[i][11:4], $sformatf("R%0d", VEC[i][3:0]));
        end
        // R9: fixed registers read their constants and ignore writes
        phy_read_check(6'd2,  K_ID_HI, "R9");
        phy_read_check(6'd3,  K_ID_LO, "R9");
        phy_read_check(6'd5,  K_PART,  "R9");
        phy_read_check(6'd6,  K_EXP,   "R9");
        phy_read_check(6'd17, K_SPS,   "R9");
        phy_read_check(6'd18, K_TEN,   "R9");
        phy_write(6'd2, 16'h0000);
        phy_read_check(6'd2, K_ID_HI, "R9");
        phy_write(6'd18, 16'hFFFF);
        phy_read_check(6'd18, K_TEN, "R9");
        // R10: unimplemented numbers read zero and writes leak nowhere
        phy_write(6'd7, 16'h9999);
        phy_read_check(6'd7, 16'h0000, "R10");
        phy_write(6'h20, 16'h1111);
        phy_read_check(6'h20, 16'h0000, "R10");
        phy_read_check(6'd0, 16'h3100, "R10");
        phy_write(6'h24, 16'h2222);
        phy_read_check(6'd4, 16'h0133, "R10");
        phy_read_check(6'h3F, 16'h0000, "R10");
        // R1: reset in mid-run restores defaults
        phy_write(6'd4, 16'h4242);
        hwrite(S_CMD, 8'h81);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(S_CMD, 8'h00, "R1");
        check(S_ADR, 8'h00, "R1");
        check(S_DHI, 8'h00, "R1");
        phy_read_check(6'd4,  16'h01E1, "R1");
        phy_read_check(6'd16, 16'h0410, "R1");
        phy_read_check(6'd0,  16'h3100, "R1");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule